// File: doc/BRIEF.md
# Cascadable Serial Control Register

This block turns a three-wire serial stream into the eight static control bits of a two-channel stepper motor driver. Data bits enter an 8-bit shift register on each rising edge of a serial clock. A strobe then copies the shift register into an 8-bit holding register, and the holding register drives two channel enables, two phase bits and a 4-bit torque code. An active-low gate input can force every control output to its off state while the held word is kept. An active-low clear empties both registers.

The serial pins are slow and have no fixed phase relation to the system clock. The clock and strobe pins therefore pass through a synchronizer chain of `SYNC_STAGES` flops and are edge-detected in the system clock domain. The data pin is delayed by the same chain, so it stays aligned with the detected clock edge. For daisy-chaining, the last shift stage is re-timed onto a data output on the falling serial clock edge. The synchronized clock and strobe are repeated on two outputs, which feed the same three inputs of the next device. Several devices in a chain then load from one stream with one strobe.

Top module: `scr_serial_ctl`

## Requirements
- R1: On each detected rising edge of `sck_i`, bit 0 of the shift register takes `sdi_i` and each bit i>0 takes bit i-1. The first bit sent after eight edges therefore sits in bit 7. Three bits 1,1,0 sent after a clear and then stored read back as 6.
- R2: `sdo_o` takes shift bit 7 only on a detected falling edge of `sck_i`. A rising edge leaves `sdo_o` unchanged, even when it changes bit 7.
- R3: A detected rising edge of `rck_i` copies the shift register into the holding register. Shifting while `rck_i` stays high, and the falling edge of `rck_i`, leave the control outputs unchanged.
- R4: While `clr_n_i` is low, both registers are zero and `sdo_o` is 0, whatever `sck_i` and `rck_i` do. After release, a store yields zero.
- R5: While `gate_n_i` is high, every control output is 0 one cycle later. The held word is kept, including a word stored while gated, and reappears once `gate_n_i` is low.
- R6: Holding-register bit 0 drives `en_a_o`, bit 1 drives `ph_a_o`, bit 2 drives `ph_b_o`, bit 3 drives `en_b_o`, and bits 7:4 drive `trq_o[3:0]` (bit 7 = `trq_o[3]`).
- R7: `cko_o` and `lko_o` repeat `sck_i` and `rck_i` delayed by `SYNC_STAGES`+1 system clock cycles.
- R8: Synchronous `rst_i` zeroes the registers, the outputs and the synchronizers, as R4 does.
- R9: When two devices are chained (`sdo_o`/`cko_o`/`lko_o` into `sdi_i`/`sck_i`/`rck_i`), sixteen bits and one strobe leave the first byte sent in the far device and the second byte in the near one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_i | input | 1 | Synchronous active-high reset |
| clr_n_i | input | 1 | Active-low clear: asserted asynchronously, released synchronously |
| gate_n_i | input | 1 | Active-low output gate; high forces all control outputs off |
| sdi_i | input | 1 | Serial data in |
| sck_i | input | 1 | Serial shift clock |
| rck_i | input | 1 | Serial store strobe |
| en_a_o | output | 1 | Channel A enable |
| ph_a_o | output | 1 | Channel A phase |
| ph_b_o | output | 1 | Channel B phase |
| en_b_o | output | 1 | Channel B enable |
| trq_o | output | 4 | Torque code |
| sdo_o | output | 1 | Cascade data out, re-timed on the serial clock fall |
| cko_o | output | 1 | Cascade serial clock out |
| lko_o | output | 1 | Cascade store strobe out |

## Verification
The bench uses the default two-stage synchronizer and places two instances in a chain. With this setup every one of the 256 byte values can be pushed through both devices in one run, each value paired with a different second byte. The chain also exposes the falling-edge re-timing of the cascade data, because the far device only holds correct words if that data is stable at its own detected rising edge. Directed sequences cover single-bit field decoding, partial shifts, gating while a store happens, and clear or reset with the serial pins held active.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef struct packed {
        logic [3:0] trq;
        logic       en_b;
        logic       ph_b;
        logic       ph_a;
        logic       en_a;
    } ctrl_word_t;

    localparam int unsigned CTRL_W   = $bits(ctrl_word_t);
    localparam int unsigned NUM_PINS = 3;
    localparam int unsigned PIN_SCK  = 0;
    localparam int unsigned PIN_RCK  = 1;
    localparam int unsigned PIN_SDI  = 2;

    // Off state for every field is zero.
    function automatic ctrl_word_t gate_word(ctrl_word_t w, logic gate_n);
        return gate_n ? ctrl_word_t'('0) : w;
    endfunction

    function automatic ctrl_word_t to_word(logic [CTRL_W-1:0] bits);
        return ctrl_word_t'(bits);
    endfunction

endpackage

// File: rtl/scr_edge_sync.sv
// Synchronizer chain with edge detection on the last two stages.
module scr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic sync_o,
    output logic dly_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], pin_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign dly_o  = chain_q[STAGES];
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/scr_clr_sync.sv
// Clear: asserted asynchronously, released after STAGES clock edges (STAGES >= 2).
module scr_clr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic clr_n_i,
    output logic clr_n_o
);
    logic [STAGES-1:0] rel_q;

    always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            rel_q <= '0;
        end else begin
            rel_q <= {rel_q[STAGES-2:0], 1'b1};
        end
    end

    assign clr_n_o = rel_q[STAGES-1];

endmodule

// File: rtl/scr_shift_reg.sv
module scr_shift_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             clr_n_i,
    input  logic             rst_i,
    input  logic             shift_en_i,
    input  logic             drop_en_i,
    input  logic             sdi_i,
    output logic [WIDTH-1:0] q_o,
    output logic             sdo_o
);
    logic [WIDTH-1:0] sh_q;
    logic             sdo_q;

    always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            sh_q  <= '0;
            sdo_q <= 1'b0;
        end else if (rst_i) begin
            sh_q  <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (shift_en_i) begin
                sh_q <= {sh_q[WIDTH-2:0], sdi_i};
            end
            if (drop_en_i) begin
                sdo_q <= sh_q[WIDTH-1];
            end
        end
    end

    assign q_o   = sh_q;
    assign sdo_o = sdo_q;

endmodule

// File: rtl/scr_store_reg.sv
module scr_store_reg
    import scr_pkg::*;
(
    input  logic       clk_i,
    input  logic       clr_n_i,
    input  logic       rst_i,
    input  logic       load_i,
    input  ctrl_word_t word_i,
    input  logic       gate_n_i,
    output ctrl_word_t ctrl_o
);
    ctrl_word_t held_q;
    ctrl_word_t out_q;

    always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            held_q <= '0;
            out_q  <= '0;
        end else if (rst_i) begin
            held_q <= '0;
            out_q  <= '0;
        end else begin
            if (load_i) begin
                held_q <= word_i;
            end
            out_q <= gate_word(held_q, gate_n_i);
        end
    end

    assign ctrl_o = out_q;

endmodule

// File: rtl/scr_serial_ctl.sv
module scr_serial_ctl
    import scr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       clr_n_i,
    input  logic       gate_n_i,
    input  logic       sdi_i,
    input  logic       sck_i,
    input  logic       rck_i,
    output logic       en_a_o,
    output logic       ph_a_o,
    output logic       ph_b_o,
    output logic       en_b_o,
    output logic [3:0] trq_o,
    output logic       sdo_o,
    output logic       cko_o,
    output logic       lko_o
);
    localparam int unsigned W = CTRL_W;

    logic [NUM_PINS-1:0] pin_raw;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_dly;
    logic [NUM_PINS-1:0] pin_rise;
    logic [NUM_PINS-1:0] pin_fall;
    logic                clr_int_n;
    logic [W-1:0]        shift_q;
    ctrl_word_t          ctrl;

    assign pin_raw[PIN_SCK] = sck_i;
    assign pin_raw[PIN_RCK] = rck_i;
    assign pin_raw[PIN_SDI] = sdi_i;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        scr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .pin_i  (pin_raw[g]),
            .sync_o (pin_sync[g]),
            .dly_o  (pin_dly[g]),
            .rise_o (pin_rise[g]),
            .fall_o (pin_fall[g])
        );
    end

    scr_clr_sync #(.STAGES(SYNC_STAGES)) u_clr (
        .clk_i   (clk_i),
        .clr_n_i (clr_n_i),
        .clr_n_o (clr_int_n)
    );

    scr_shift_reg #(.WIDTH(W)) u_shift (
        .clk_i      (clk_i),
        .clr_n_i    (clr_int_n),
        .rst_i      (rst_i),
        .shift_en_i (pin_rise[PIN_SCK]),
        .drop_en_i  (pin_fall[PIN_SCK]),
        .sdi_i      (pin_sync[PIN_SDI]),
        .q_o        (shift_q),
        .sdo_o      (sdo_o)
    );

    scr_store_reg u_store (
        .clk_i    (clk_i),
        .clr_n_i  (clr_int_n),
        .rst_i    (rst_i),
        .load_i   (pin_rise[PIN_RCK]),
        .word_i   (to_word(shift_q)),
        .gate_n_i (gate_n_i),
        .ctrl_o   (ctrl)
    );

    assign en_a_o = ctrl.en_a;
    assign ph_a_o = ctrl.ph_a;
    assign ph_b_o = ctrl.ph_b;
    assign en_b_o = ctrl.en_b;
    assign trq_o  = ctrl.trq;
    assign cko_o  = pin_dly[PIN_SCK];
    assign lko_o  = pin_dly[PIN_RCK];

endmodule

// File: rtl/scr_serial_ctl_chk.sv
module scr_serial_ctl_chk #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       clr_n_i,
    input logic       gate_n_i,
    input logic       sck_i,
    input logic       rck_i,
    input logic       en_a_o,
    input logic       ph_a_o,
    input logic       ph_b_o,
    input logic       en_b_o,
    input logic [3:0] trq_o,
    input logic       sdo_o,
    input logic       cko_o,
    input logic       lko_o
);
    logic [7:0]             word;
    logic                   rst_d;
    logic [SYNC_STAGES:0]   dl_sck;
    logic [SYNC_STAGES:0]   dl_rck;
    int unsigned            run_cnt;
    logic                   fwd_ok;

    assign word   = {trq_o, en_b_o, ph_b_o, ph_a_o, en_a_o};
    assign fwd_ok = (run_cnt > SYNC_STAGES);

    always_ff @(posedge clk_i) begin
        rst_d  <= rst_i;
        dl_sck <= {dl_sck[SYNC_STAGES-1:0], sck_i};
        dl_rck <= {dl_rck[SYNC_STAGES-1:0], rck_i};
        if (rst_i) begin
            run_cnt <= 0;
        end else if (run_cnt <= SYNC_STAGES) begin
            run_cnt <= run_cnt + 1;
        end
    end

    AST_CDOUT_ON_FALL_ONLY: assert property (@(posedge clk_i) disable iff (rst_i || rst_d || !clr_n_i)
        !$fell(cko_o) |-> $stable(sdo_o)); // R2

    AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i || rst_d || !clr_n_i)
        (!$rose(lko_o) && $stable(gate_n_i)) |=> $stable(word)); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !clr_n_i |-> (word == 8'h00 && sdo_o == 1'b0)); // R4

    AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_n_i |=> (word == 8'h00)); // R5

    AST_CKO_FOLLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        fwd_ok |-> (cko_o == dl_sck[SYNC_STAGES])); // R7

    AST_LKO_FOLLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        fwd_ok |-> (lko_o == dl_rck[SYNC_STAGES])); // R7

endmodule

bind scr_serial_ctl scr_serial_ctl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .clr_n_i  (clr_n_i),
    .gate_n_i (gate_n_i),
    .sck_i    (sck_i),
    .rck_i    (rck_i),
    .en_a_o   (en_a_o),
    .ph_a_o   (ph_a_o),
    .ph_b_o   (ph_b_o),
    .en_b_o   (en_b_o),
    .trq_o    (trq_o),
    .sdo_o    (sdo_o),
    .cko_o    (cko_o),
    .lko_o    (lko_o)
);

// File: tb/scr_serial_ctl_tb_top.sv
module scr_serial_ctl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, clr_n, gate_n, sdi, sck, rck;

    logic       a_en_a, a_ph_a, a_ph_b, a_en_b, a_sdo, a_cko, a_lko;
    logic [3:0] a_trq;
    logic       b_en_a, b_ph_a, b_ph_b, b_en_b, b_sdo, b_cko, b_lko;
    logic [3:0] b_trq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scr_serial_ctl dut_i (
        .clk_i(clk), .rst_i(rst), .clr_n_i(clr_n), .gate_n_i(gate_n),
        .sdi_i(sdi), .sck_i(sck), .rck_i(rck),
        .en_a_o(a_en_a), .ph_a_o(a_ph_a), .ph_b_o(a_ph_b), .en_b_o(a_en_b),
        .trq_o(a_trq), .sdo_o(a_sdo), .cko_o(a_cko), .lko_o(a_lko)
    );

    scr_serial_ctl dut_far_i (
        .clk_i(clk), .rst_i(rst), .clr_n_i(clr_n), .gate_n_i(gate_n),
        .sdi_i(a_sdo), .sck_i(a_cko), .rck_i(a_lko),
        .en_a_o(b_en_a), .ph_a_o(b_ph_a), .ph_b_o(b_ph_b), .en_b_o(b_en_b),
        .trq_o(b_trq), .sdo_o(b_sdo), .cko_o(b_cko), .lko_o(b_lko)
    );

    function automatic int near_word();
        return int'({a_trq, a_en_b, a_ph_b, a_ph_a, a_en_a});
    endfunction

    function automatic int far_word();
        return int'({b_trq, b_en_b, b_ph_b, b_ph_a, b_en_a});
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        sdi = b;
        wait_cyc(2);
        sck = 1'b1;
        wait_cyc(4);
        sck = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic latch_pulse();
        rck = 1'b1;
        wait_cyc(4);
        rck = 1'b0;
        wait_cyc(10);
    endtask

    task automatic do_clear();
        clr_n = 1'b0;
        wait_cyc(3);
        clr_n = 1'b1;
        wait_cyc(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clr_n = 1'b0; gate_n = 1'b1;
        sdi = 1'b0; sck = 1'b0; rck = 1'b0;
        wait_cyc(4);
        clr_n = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(3);

        // Reset state (R8)
        chk("R8 reset word", near_word(), 0);
        chk("R8 reset sdo", int'(a_sdo), 0);
        chk("R8 reset cko/lko", int'({a_cko, a_lko}), 0);

        // R7 forward latency: SYNC_STAGES+1 = 3 cycles
        sck = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 cko before latency", int'(a_cko), 0);
        @(posedge clk); @(negedge clk);
        chk("R7 cko after latency", int'(a_cko), 1);
        sck = 1'b0;
        wait_cyc(6);
        rck = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 lko before latency", int'(a_lko), 0);
        @(posedge clk); @(negedge clk);
        chk("R7 lko after latency", int'(a_lko), 1);
        rck = 1'b0;
        wait_cyc(8);
        gate_n = 1'b0;
        wait_cyc(2);

        // R6 single-bit field decode
        for (int k = 0; k < 8; k++) begin
            send_byte(8'(1 << k));
            latch_pulse();
            chk("R6 en_a", int'(a_en_a), (k == 0) ? 1 : 0);
            chk("R6 ph_a", int'(a_ph_a), (k == 1) ? 1 : 0);
            chk("R6 ph_b", int'(a_ph_b), (k == 2) ? 1 : 0);
            chk("R6 en_b", int'(a_en_b), (k == 3) ? 1 : 0);
            chk("R6 trq", int'(a_trq), (k >= 4) ? (1 << (k - 4)) : 0);
        end

        // R1 partial shift after clear
        do_clear();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        latch_pulse();
        chk("R1 partial shift", near_word(), 6);

        // R2 cascade data re-timed on the fall
        do_clear();
        send_byte(8'h80);
        chk("R2 sdo after fall", int'(a_sdo), 1);
        sdi = 1'b0;
        wait_cyc(2);
        sck = 1'b1;
        wait_cyc(6);
        chk("R2 sdo held on rise", int'(a_sdo), 1);
        sck = 1'b0;
        wait_cyc(6);
        chk("R2 sdo updated on fall", int'(a_sdo), 0);

        // R3 store only on strobe rise
        send_byte(8'h5A);
        rck = 1'b1;
        wait_cyc(8);
        chk("R3 stored on rise", near_word(), 8'h5A);
        send_byte(8'hFF);
        chk("R3 shift with strobe high", near_word(), 8'h5A);
        rck = 1'b0;
        wait_cyc(8);
        chk("R3 strobe fall no copy", near_word(), 8'h5A);
        latch_pulse();
        chk("R3 next store", near_word(), 8'hFF);

        // R5 gate
        send_byte(8'hA5);
        latch_pulse();
        chk("R5 ungated word", near_word(), 8'hA5);
        gate_n = 1'b1;
        wait_cyc(2);
        chk("R5 gated word", near_word(), 0);
        gate_n = 1'b0;
        wait_cyc(2);
        chk("R5 word kept", near_word(), 8'hA5);
        gate_n = 1'b1;
        send_byte(8'h3C);
        latch_pulse();
        chk("R5 gated during store", near_word(), 0);
        gate_n = 1'b0;
        wait_cyc(2);
        chk("R5 gated store kept", near_word(), 8'h3C);

        // R4 clear with pins active
        sck = 1'b1; rck = 1'b1; clr_n = 1'b0;
        wait_cyc(2);
        chk("R4 near word in clear", near_word(), 0);
        chk("R4 sdo in clear", int'(a_sdo), 0);
        chk("R4 far word in clear", far_word(), 0);
        sck = 1'b0; rck = 1'b0; clr_n = 1'b1;
        wait_cyc(6);
        latch_pulse();
        chk("R4 shift emptied", near_word(), 0);

        // R8 synchronous reset
        send_byte(8'h77);
        latch_pulse();
        chk("R8 loaded", near_word(), 8'h77);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(2);
        chk("R8 word after reset", near_word(), 0);
        latch_pulse();
        chk("R8 shift after reset", near_word(), 0);

        // R1 / R9 exhaustive sweep through the chain
        for (int v = 0; v < 256; v++) begin
            logic [7:0] first_b;
            logic [7:0] second_b;
            first_b  = 8'(v);
            second_b = 8'((v * 37 + 11) % 256);
            send_byte(first_b);
            send_byte(second_b);
            latch_pulse();
            chk("R1 near device word", near_word(), int'(second_b));
            chk("R9 far device word", far_word(), int'(first_b));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule